// File: doc/BRIEF.md
# I/O Channel Ready Wait-State Controller

This block controls the I/O channel ready line of a network adapter card on a 16-bit expansion bus. It compares the upper address bits against the card's base address. The next two address bits split the card's space into three parts: a controller register bank, a data port latch, and an unused hole. While the card-side logic cannot yet finish a transfer, the block pulls ready low to stretch the host's cycle. It never drives the line high. When released, the line floats and reads as ready.

A static strap selects the timing. In normal timing, the block asserts not-ready only while an I/O read or write command is active. In early timing, it can also assert not-ready on the address alone for 16-bit data-port cycles, so hosts that sample ready before the command strobe see a valid level. This early drive only happens inside a window. The window opens with address latch enable and closes on the first bus clock rise after that strobe falls. A memory command inside the window cancels the early drive. A port request line that is not yet driven counts as asserted, so the host can never be stuck in wait states.

All inputs are sampled in the core clock domain. The drive enable comes from a register, so it cannot glitch.

Top module: `isa_rdy_ctrl`

## Requirements
- R1: After reset, `rdy_oe` is 0. `rdy_o` is always 0, so the line is either pulled low or left floating.
- R2: The card is selected only when `addr[9:5]` equals parameter `BASE_SEL` (default 5'h18). With no match, `rdy_oe` is 0 one clock later.
- R3: A register access has `addr[4]`=0. With the card selected, `io_rd` or `io_wr` high, and `ctl_ack` low, `rdy_oe` is 1 one clock later. Once `ctl_ack` is high, `rdy_oe` is 0 one clock later.
- R4: A data-port access has `addr[4]`=1 and `addr[3]`=0. With the card selected, a command active, and the effective port request low, `rdy_oe` is 1 one clock later. With the request high it is 0. Addresses with `addr[4]`=1 and `addr[3]`=1 never drive.
- R5: Early drive happens when all of these hold: `early_en`=1, `wide_xfer`=1, the window is open, the address is a selected data port, and the effective request is low. It needs no I/O command, and it sets `rdy_oe`=1 one clock later.
- R6: While `mem_rd` or `mem_wr` is high, early drive is suppressed.
- R7: The window opens on any clock that samples `ale`=1. It stays open while `ale`=0 until the first sampled low-to-high change of `bus_clk`. In that same clock it is treated as closed.
- R8: With `early_en`=0 or `wide_xfer`=0, `rdy_oe` follows only the command-qualified terms of R3 and R4.
- R9: The effective port request is `port_req | ~port_req_oe`. While `port_req_oe`=0, a data-port access never drives ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 10 | Bus I/O address |
| io_rd | input | 1 | I/O read command, active high |
| io_wr | input | 1 | I/O write command, active high |
| mem_rd | input | 1 | Memory read command, active high |
| mem_wr | input | 1 | Memory write command, active high |
| ale | input | 1 | Address latch enable |
| bus_clk | input | 1 | Bus system clock level |
| wide_xfer | input | 1 | 1 for a 16-bit transfer |
| early_en | input | 1 | Strap: 1 allows early timing |
| ctl_ack | input | 1 | Controller acknowledge for register access |
| port_req | input | 1 | Port request: latch holds data |
| port_req_oe | input | 1 | 1 when the port request line is driven |
| rdy_oe | output | 1 | Enable of the open-drain ready driver |
| rdy_o | output | 1 | Ready driver data, constant 0 |

## Verification
A window register stuck open would keep not-ready asserted on data-port addresses after the bus clock rise that should end the window. That shows up at `rdy_oe` one clock after that rise. A stuck-closed window would show the opposite: no early drive one clock after `ale`. A wrong decode of the target or of the request polarity flips `rdy_oe` one clock after the command changes. The bench checks at that point on every cycle it cares about.

// File: rtl/isa_rdy_pkg.sv
package isa_rdy_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_REG  = 2'd1,
    TGT_PORT = 2'd2
  } tgt_e;
endpackage

// File: rtl/isa_rdy_dec.sv
module isa_rdy_dec
  import isa_rdy_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SEL_LO = 5,
  parameter logic [ADDR_W-SEL_LO-1:0] BASE_SEL = '1
) (
  input  logic [ADDR_W-1:0] addr,
  output tgt_e              tgt
);
  localparam int SEL_W = ADDR_W - SEL_LO;

  logic card_hit;

  always_comb begin
    card_hit = (addr[ADDR_W-1:SEL_LO] == BASE_SEL[SEL_W-1:0]);
    tgt      = TGT_NONE;
    if (card_hit) begin
      if (!addr[SEL_LO-1])
        tgt = TGT_REG;
      else if (!addr[SEL_LO-2])
        tgt = TGT_PORT;
    end
  end
endmodule

// File: rtl/isa_rdy_win.sv
module isa_rdy_win (
  input  logic clk,
  input  logic rst_n,
  input  logic ale,
  input  logic bus_clk,
  output logic win_open
);
  logic win_q, win_d;
  logic bclk_q;
  logic bclk_rise;

  always_comb begin
    bclk_rise = bus_clk & ~bclk_q;
    win_open  = ale | (win_q & ~bclk_rise);
    win_d     = win_open;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      bclk_q <= 1'b0;
    end else begin
      win_q  <= win_d;
      bclk_q <= bus_clk;
    end
  end
endmodule

// File: rtl/isa_rdy_gen.sv
module isa_rdy_gen
  import isa_rdy_pkg::*;
(
  input  tgt_e tgt,
  input  logic io_cmd,
  input  logic mem_cmd,
  input  logic ack,
  input  logic req_eff,
  input  logic early_ok,
  output logic hold_n
);
  logic norm_term, early_term;

  always_comb begin
    norm_term  = io_cmd & (((tgt == TGT_REG) & ~ack) |
                           ((tgt == TGT_PORT) & ~req_eff));
    early_term = early_ok & ~mem_cmd & (tgt == TGT_PORT) & ~req_eff;
    hold_n     = norm_term | early_term;
  end
endmodule

// File: rtl/isa_rdy_ctrl.sv
module isa_rdy_ctrl
  import isa_rdy_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SEL_LO = 5,
  parameter logic [ADDR_W-SEL_LO-1:0] BASE_SEL = 5'h18,
  parameter bit EARLY_SUPPORT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic              mem_rd,
  input  logic              mem_wr,
  input  logic              ale,
  input  logic              bus_clk,
  input  logic              wide_xfer,
  input  logic              early_en,
  input  logic              ctl_ack,
  input  logic              port_req,
  input  logic              port_req_oe,
  output logic              rdy_oe,
  output logic              rdy_o
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  tgt_e       tgt;
  logic       win_open;
  logic       early_ok;
  logic       req_eff;
  logic       drive_d, drive_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  isa_rdy_dec #(.ADDR_W(ADDR_W), .SEL_LO(SEL_LO), .BASE_SEL(BASE_SEL)) u_dec (
    .addr (addr),
    .tgt  (tgt)
  );

  generate
    if (EARLY_SUPPORT) begin : g_early
      isa_rdy_win u_win (
        .clk      (clk),
        .rst_n    (rst_core_n),
        .ale      (ale),
        .bus_clk  (bus_clk),
        .win_open (win_open)
      );
    end else begin : g_no_early
      assign win_open = 1'b0;
    end
  endgenerate

  always_comb begin
    req_eff  = port_req | ~port_req_oe;
    early_ok = early_en & wide_xfer & win_open;
  end

  isa_rdy_gen u_gen (
    .tgt     (tgt),
    .io_cmd  (io_rd | io_wr),
    .mem_cmd (mem_rd | mem_wr),
    .ack     (ctl_ack),
    .req_eff (req_eff),
    .early_ok(early_ok),
    .hold_n  (drive_d)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) drive_q <= 1'b0;
    else             drive_q <= drive_d;
  end

  assign rdy_oe = drive_q;
  assign rdy_o  = 1'b0;
endmodule

// File: rtl/isa_rdy_chk.sv
module isa_rdy_chk #(
  parameter int ADDR_W = 10,
  parameter int SEL_LO = 5,
  parameter logic [ADDR_W-SEL_LO-1:0] BASE_SEL = 5'h18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              io_rd,
  input logic              io_wr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              early_en,
  input logic              ctl_ack,
  input logic              port_req_oe,
  input logic              rdy_oe
);
  logic sel;
  assign sel = (addr[ADDR_W-1:SEL_LO] == BASE_SEL);

  assert_unsel_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !rdy_oe);

  assert_reg_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !addr[SEL_LO-1] && (io_rd || io_wr) && !ctl_ack) |=> rdy_oe);

  assert_reg_ack_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr[SEL_LO-1] && ctl_ack) |=> !rdy_oe);

  assert_mem_no_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && !io_rd && !io_wr) |=> !rdy_oe);

  assert_normal_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!early_en && !io_rd && !io_wr) |=> !rdy_oe);

  assert_float_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_req_oe && addr[SEL_LO-1]) |=> !rdy_oe);
endmodule

bind isa_rdy_ctrl isa_rdy_chk #(.ADDR_W(ADDR_W), .SEL_LO(SEL_LO), .BASE_SEL(BASE_SEL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .io_rd      (io_rd),
  .io_wr      (io_wr),
  .mem_rd     (mem_rd),
  .mem_wr     (mem_wr),
  .early_en   (early_en),
  .ctl_ack    (ctl_ack),
  .port_req_oe(port_req_oe),
  .rdy_oe     (rdy_oe)
);

// File: tb/test_isa_rdy_ctrl.sv
`timescale 1ns/1ps
module test_isa_rdy_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] addr;
  logic       io_rd, io_wr, mem_rd, mem_wr, ale, bus_clk;
  logic       wide_xfer, early_en, ctl_ack, port_req, port_req_oe;
  logic       rdy_oe, rdy_o;
  int         total = 0;
  int         bad = 0;

  localparam logic [9:0] A_REG  = 10'h300;
  localparam logic [9:0] A_PORT = 10'h310;
  localparam logic [9:0] A_HOLE = 10'h318;
  localparam logic [9:0] A_OFF  = 10'h210;

  always #2.5 clk = ~clk;

  isa_rdy_ctrl i_isa_rdy_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .io_rd(io_rd), .io_wr(io_wr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .ale(ale), .bus_clk(bus_clk),
    .wide_xfer(wide_xfer), .early_en(early_en), .ctl_ack(ctl_ack),
    .port_req(port_req), .port_req_oe(port_req_oe),
    .rdy_oe(rdy_oe), .rdy_o(rdy_o)
  );

  task automatic chk(input logic exp, input string tag);
    total++;
    if (rdy_oe !== exp || rdy_o !== 1'b0) begin
      bad++;
      $display("FAIL %s: rdy_oe=%b rdy_o=%b expected rdy_oe=%b rdy_o=0",
               tag, rdy_oe, rdy_o, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    addr = A_OFF; io_rd = 0; io_wr = 0; mem_rd = 0; mem_wr = 0; ale = 0;
    bus_clk = 0; wide_xfer = 0; early_en = 0; ctl_ack = 0;
    port_req = 0; port_req_oe = 1;
    tick(); tick(); tick();
  endtask

  task automatic t_reset();
    rst_n = 0;
    addr = A_PORT; io_rd = 1; io_wr = 0; mem_rd = 0; mem_wr = 0; ale = 0;
    bus_clk = 0; wide_xfer = 1; early_en = 1; ctl_ack = 0;
    port_req = 0; port_req_oe = 1;
    tick(); tick();
    chk(1'b0, "R1 reset");
    rst_n = 1;
    idle();
    chk(1'b0, "R1 idle after reset");
  endtask

  task automatic t_register();
    addr = A_REG; io_rd = 1; tick();
    chk(1'b1, "R3 register read wait");
    ctl_ack = 1; tick();
    chk(1'b0, "R3 ack releases");
    io_rd = 0; ctl_ack = 0; io_wr = 1; tick();
    chk(1'b1, "R3 register write wait");
    idle();
  endtask

  task automatic t_unselected();
    addr = A_OFF; io_rd = 1; tick();
    chk(1'b0, "R2 other base not driven");
    addr = A_REG; tick();
    chk(1'b1, "R2 own base driven");
    idle();
  endtask

  task automatic t_port();
    addr = A_PORT; io_wr = 1; port_req = 0; tick();
    chk(1'b1, "R4 port wait");
    port_req = 1; tick();
    chk(1'b0, "R4 request releases");
    port_req = 0; addr = A_HOLE; tick();
    chk(1'b0, "R4 hole not driven");
    idle();
  endtask

  task automatic t_early();
    early_en = 1; wide_xfer = 1; addr = A_PORT; ale = 1; tick();
    chk(1'b1, "R5 early drive on decode");
    ale = 0; tick();
    chk(1'b1, "R7 window held after ale");
    bus_clk = 1; tick();
    chk(1'b0, "R7 window closed by bus clock rise");
    io_rd = 1; tick();
    chk(1'b1, "R7 normal drive after window");
    idle();
  endtask

  task automatic t_mem();
    early_en = 1; wide_xfer = 1; addr = A_PORT; ale = 1; mem_rd = 1; tick();
    chk(1'b0, "R6 memory read suppresses");
    mem_rd = 0; mem_wr = 1; tick();
    chk(1'b0, "R6 memory write suppresses");
    mem_wr = 0; tick();
    chk(1'b1, "R6 early resumes without memory command");
    idle();
  endtask

  task automatic t_mode();
    early_en = 0; wide_xfer = 1; addr = A_PORT; ale = 1; tick();
    chk(1'b0, "R8 strap off no early");
    early_en = 1; wide_xfer = 0; tick();
    chk(1'b0, "R8 8-bit no early");
    io_rd = 1; tick();
    chk(1'b1, "R8 8-bit normal drive");
    idle();
  endtask

  task automatic t_float();
    addr = A_PORT; io_rd = 1; port_req_oe = 0; port_req = 0; tick();
    chk(1'b0, "R9 undriven request counts as asserted");
    early_en = 1; wide_xfer = 1; ale = 1; tick();
    chk(1'b0, "R9 undriven request no early");
    port_req_oe = 1; tick();
    chk(1'b1, "R9 driven low request waits");
    idle();
  endtask

  initial begin
    t_reset();
    t_register();
    t_unselected();
    t_port();
    t_early();
    t_mem();
    t_mode();
    t_float();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule